// File: doc/BRIEF.md
# Decode-Stage Branch Prediction Checker

This block sits in the decode stage of an out-of-order core. Each cycle it looks at a group of up to `W` decoded instructions. For each one it uses the control-flow class, the predicted-taken bit, the predicted target and the direct target computed at decode. It finds two kinds of early misprediction:

- an instruction that was predicted taken but is not a control instruction at all;
- a direct branch whose computed target differs from the predicted one.

The oldest such instruction in the group produces a single redirect record toward fetch, one cycle later. The record carries the corrected next PC, the taken direction, the cause and the squash sequence number. In the same cycle as the redirect, the block produces a kill mask over the decode skid buffer. The group itself is forwarded with the same-thread younger instructions dropped, and with the offending branch's predicted target replaced by the computed one. Indirect branches are never judged here.

Each hardware thread also has a small two-state controller for the block/unblock handshake with fetch. The states are `TS_FLOW` and `TS_HOLD`. The transitions are:

- STALL (`TS_FLOW` to `TS_HOLD`): the downstream block request is raised and the thread is not being squashed.
- RESUME (`TS_HOLD` to `TS_FLOW`): the block request is released.
- FLUSH (either state to `TS_FLOW`): decode squashes that thread. FLUSH always sends an unblock pulse.

Top module: `decode_branch_check`

## Requirements
- R1: After reset, `rd_valid`, `out_vld`, `sk_kill`, `fetch_block` and `fetch_unblock` are all zero, and every thread is in `TS_FLOW`.
- R2: A valid instruction with `in_pred_taken`=1 and `in_ctrl`=0 causes a redirect with `rd_ctrl_bad`=1, `rd_tgt_bad`=0, `rd_taken`=0 and `rd_next_pc` = its PC + `INST_BYTES`.
- R3: A valid instruction with `in_ctrl`=1 and `in_direct`=1 that is unconditional or predicted taken, and whose `in_calc_tgt` differs from `in_pred_tgt`, causes a redirect with `rd_tgt_bad`=1, `rd_ctrl_bad`=0 and `rd_next_pc` = `in_calc_tgt`.
- R4: On a target-mismatch redirect, `rd_taken` is 1. This holds even for an unconditional branch whose predicted-taken bit was 0.
- R5: No redirect results from any of these: an invalid slot, a matching target, a direct conditional predicted not taken, or an indirect control (`in_direct`=0).
- R6: The redirect is a registered result, visible exactly one cycle after the group. `rd_seq` and `rd_tid` are the offending instruction's sequence number and thread. Exactly one of `rd_ctrl_bad` and `rd_tgt_bad` is set while `rd_valid`=1.
- R7: When several slots would trigger, only the one with the lowest sequence number produces the redirect, whatever its slot index or thread.
- R8: `out_vld` (one cycle after the group) drops every slot of the redirecting thread whose sequence number is greater than the squash number. Older slots and slots of other threads are forwarded.
- R9: The forwarded target `out_tgt` of the redirecting slot, on a target mismatch, is its computed target. Every other forwarded slot keeps its predicted target, including a triggering slot of another thread that lost to an older one.
- R10: While `rd_valid`=1, `sk_kill[k]` is 1 exactly for valid skid entries of thread `rd_tid` whose sequence number exceeds `rd_seq`. Otherwise it is 0.
- R11: A thread's `blk_req` raised in `TS_FLOW` sets `fetch_block` one cycle later. Releasing it in `TS_HOLD` clears `fetch_block` and pulses `fetch_unblock` for one cycle.
- R12: A redirect on a thread forces that thread to `TS_FLOW` (`fetch_block`=0) and pulses its `fetch_unblock`, in the same cycle as `rd_valid`, even if `blk_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | W | Slot valid |
| in_tid | input | W*TW | Slot thread |
| in_seq | input | W*SW | Slot sequence number (larger is younger) |
| in_pc | input | W*AW | Slot PC |
| in_ctrl | input | W | Slot is a control instruction |
| in_direct | input | W | Control target is PC-relative or absolute (direct) |
| in_uncond | input | W | Control is unconditional |
| in_pred_taken | input | W | Predictor said taken |
| in_pred_tgt | input | W*AW | Predicted target |
| in_calc_tgt | input | W*AW | Target computed at decode |
| out_vld | output | W | Forwarded slot valid |
| out_tgt | output | W*AW | Forwarded (possibly corrected) predicted target |
| rd_valid | output | 1 | Redirect pulse |
| rd_tid | output | TW | Redirect thread |
| rd_seq | output | SW | Squash sequence number |
| rd_next_pc | output | AW | Redirect fetch PC |
| rd_taken | output | 1 | Redirect direction |
| rd_ctrl_bad | output | 1 | Cause: non-control predicted taken |
| rd_tgt_bad | output | 1 | Cause: direct target mismatch |
| sk_vld | input | D | Skid entry valid |
| sk_tid | input | D*TW | Skid entry thread |
| sk_seq | input | D*SW | Skid entry sequence number |
| sk_kill | output | D | Skid entries to remove |
| blk_req | input | THREADS | Downstream block request per thread |
| fetch_block | output | THREADS | Block signal to fetch |
| fetch_unblock | output | THREADS | Unblock pulse to fetch |

## Verification
The assertions assume that sequence numbers never wrap inside one observation window. They also assume that the skid contents on `sk_*` are stable during the cycle in which `rd_valid` is shown. The stimulus uses small, distinct, increasing sequence numbers per scenario. It holds each skid picture for a whole cycle, from one falling edge to the next. It never drives a group in which two slots share a sequence number, so the oldest trigger is always unique.

// File: rtl/brchk_pkg.sv
package brchk_pkg;

    typedef enum logic [0:0] {
        TS_FLOW = 1'b0,
        TS_HOLD = 1'b1
    } thr_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_NOTCTRL = 2'd1,
        CAUSE_TARGET  = 2'd2
    } cause_e;

endpackage

// File: rtl/brchk_slot_eval.sv
module brchk_slot_eval
    import brchk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INST_BYTES = 4
) (
    input  logic          vld,
    input  logic [AW-1:0] pc,
    input  logic          is_ctrl,
    input  logic          is_direct,
    input  logic          is_uncond,
    input  logic          pred_taken,
    input  logic [AW-1:0] pred_tgt,
    input  logic [AW-1:0] calc_tgt,
    output cause_e        cause,
    output logic [AW-1:0] redir_pc,
    output logic          redir_taken,
    output logic [AW-1:0] fwd_tgt
);

    logic judged;
    assign judged = is_ctrl && is_direct && (is_uncond || pred_taken);

    always_comb begin
        cause       = CAUSE_NONE;
        redir_pc    = calc_tgt;
        redir_taken = 1'b0;
        fwd_tgt     = pred_tgt;
        if (vld) begin
            if (pred_taken && !is_ctrl) begin
                cause       = CAUSE_NOTCTRL;
                redir_pc    = pc + AW'(INST_BYTES);
                redir_taken = 1'b0;
            end else if (judged && (calc_tgt != pred_tgt)) begin
                cause       = CAUSE_TARGET;
                redir_pc    = calc_tgt;
                redir_taken = is_uncond ? 1'b1 : pred_taken;
                fwd_tgt     = calc_tgt;
            end
        end
    end

endmodule

// File: rtl/brchk_oldest_pick.sv
module brchk_oldest_pick #(
    parameter int W  = 4,
    parameter int SW = 16
) (
    input  logic [W-1:0]    trig,
    input  logic [W*SW-1:0] seq,
    output logic [W-1:0]    win_oh,
    output logic            any
);

    logic [SW-1:0] best;
    int            best_i;

    always_comb begin
        best   = '0;
        best_i = -1;
        for (int i = 0; i < W; i++) begin
            if (trig[i] && (best_i < 0 || seq[i*SW +: SW] < best)) begin
                best   = seq[i*SW +: SW];
                best_i = i;
            end
        end
        win_oh = '0;
        for (int i = 0; i < W; i++) begin
            if (best_i == i) win_oh[i] = 1'b1;
        end
        any = (best_i >= 0);
    end

endmodule

// File: rtl/brchk_thread_fsm.sv
module brchk_thread_fsm
    import brchk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_req,
    input  logic squash,
    output logic fetch_block,
    output logic fetch_unblock
);

    thr_state_e state, state_nx;
    logic       unblock_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TS_FLOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        unblock_d = 1'b0;
        unique case (state)
            TS_FLOW: begin
                if (squash) begin
                    state_nx  = TS_FLOW;      // FLUSH
                    unblock_d = 1'b1;
                end else if (blk_req) begin
                    state_nx  = TS_HOLD;      // STALL
                end
            end
            TS_HOLD: begin
                if (squash || !blk_req) begin
                    state_nx  = TS_FLOW;      // FLUSH or RESUME
                    unblock_d = 1'b1;
                end
            end
            default: state_nx = TS_FLOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fetch_unblock <= 1'b0;
        else        fetch_unblock <= unblock_d;
    end

    assign fetch_block = (state == TS_HOLD);

    // R12
    flush_to_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (state == TS_FLOW) && fetch_unblock);

    // R11
    hold_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_HOLD) |-> $past(blk_req));

    // R11
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_HOLD) && !blk_req |=> fetch_unblock && !fetch_block);

endmodule

// File: rtl/brchk_kill_mask.sv
module brchk_kill_mask #(
    parameter int D  = 8,
    parameter int TW = 1,
    parameter int SW = 16
) (
    input  logic            rd_valid,
    input  logic [TW-1:0]   rd_tid,
    input  logic [SW-1:0]   rd_seq,
    input  logic [D-1:0]    sk_vld,
    input  logic [D*TW-1:0] sk_tid,
    input  logic [D*SW-1:0] sk_seq,
    output logic [D-1:0]    kill
);

    for (genvar k = 0; k < D; k++) begin : g_ent
        assign kill[k] = rd_valid && sk_vld[k]
                      && (sk_tid[k*TW +: TW] == rd_tid)
                      && (sk_seq[k*SW +: SW] > rd_seq);
    end

endmodule

// File: rtl/decode_branch_check.sv
module decode_branch_check
    import brchk_pkg::*;
#(
    parameter int W          = 4,
    parameter int THREADS    = 2,
    parameter int SW         = 16,
    parameter int AW         = 32,
    parameter int D          = 8,
    parameter int INST_BYTES = 4,
    localparam int TW        = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        in_vld,
    input  logic [W*TW-1:0]     in_tid,
    input  logic [W*SW-1:0]     in_seq,
    input  logic [W*AW-1:0]     in_pc,
    input  logic [W-1:0]        in_ctrl,
    input  logic [W-1:0]        in_direct,
    input  logic [W-1:0]        in_uncond,
    input  logic [W-1:0]        in_pred_taken,
    input  logic [W*AW-1:0]     in_pred_tgt,
    input  logic [W*AW-1:0]     in_calc_tgt,
    output logic [W-1:0]        out_vld,
    output logic [W*AW-1:0]     out_tgt,
    output logic                rd_valid,
    output logic [TW-1:0]       rd_tid,
    output logic [SW-1:0]       rd_seq,
    output logic [AW-1:0]       rd_next_pc,
    output logic                rd_taken,
    output logic                rd_ctrl_bad,
    output logic                rd_tgt_bad,
    input  logic [D-1:0]        sk_vld,
    input  logic [D*TW-1:0]     sk_tid,
    input  logic [D*SW-1:0]     sk_seq,
    output logic [D-1:0]        sk_kill,
    input  logic [THREADS-1:0]  blk_req,
    output logic [THREADS-1:0]  fetch_block,
    output logic [THREADS-1:0]  fetch_unblock
);

    cause_e          cause    [W];
    logic [AW-1:0]   rpc      [W];
    logic [W-1:0]    rtaken;
    logic [AW-1:0]   ftgt     [W];
    logic [W-1:0]    trig;
    logic [W-1:0]    win_oh;
    logic            any_trig;

    for (genvar i = 0; i < W; i++) begin : g_slot
        brchk_slot_eval #(.AW(AW), .INST_BYTES(INST_BYTES)) u_eval (
            .vld        (in_vld[i]),
            .pc         (in_pc[i*AW +: AW]),
            .is_ctrl    (in_ctrl[i]),
            .is_direct  (in_direct[i]),
            .is_uncond  (in_uncond[i]),
            .pred_taken (in_pred_taken[i]),
            .pred_tgt   (in_pred_tgt[i*AW +: AW]),
            .calc_tgt   (in_calc_tgt[i*AW +: AW]),
            .cause      (cause[i]),
            .redir_pc   (rpc[i]),
            .redir_taken(rtaken[i]),
            .fwd_tgt    (ftgt[i])
        );
        assign trig[i] = (cause[i] != CAUSE_NONE);
    end

    brchk_oldest_pick #(.W(W), .SW(SW)) u_pick (
        .trig  (trig),
        .seq   (in_seq),
        .win_oh(win_oh),
        .any   (any_trig)
    );

    // winner fields
    logic [TW-1:0] w_tid;
    logic [SW-1:0] w_seq;
    logic [AW-1:0] w_pc;
    logic          w_taken;
    cause_e        w_cause;

    always_comb begin
        w_tid   = '0;
        w_seq   = '0;
        w_pc    = '0;
        w_taken = 1'b0;
        w_cause = CAUSE_NONE;
        for (int i = 0; i < W; i++) begin
            if (win_oh[i]) begin
                w_tid   = in_tid[i*TW +: TW];
                w_seq   = in_seq[i*SW +: SW];
                w_pc    = rpc[i];
                w_taken = rtaken[i];
                w_cause = cause[i];
            end
        end
    end

    // forwarding: drop same-thread younger, fix winner target
    logic [W-1:0]    keep;
    logic [W*AW-1:0] fwd_tgt;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            keep[i] = in_vld[i] && !(any_trig
                       && (in_tid[i*TW +: TW] == w_tid)
                       && (in_seq[i*SW +: SW] > w_seq));
            fwd_tgt[i*AW +: AW] = win_oh[i] ? ftgt[i] : in_pred_tgt[i*AW +: AW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld     <= '0;
            out_tgt     <= '0;
            rd_valid    <= 1'b0;
            rd_tid      <= '0;
            rd_seq      <= '0;
            rd_next_pc  <= '0;
            rd_taken    <= 1'b0;
            rd_ctrl_bad <= 1'b0;
            rd_tgt_bad  <= 1'b0;
        end else begin
            out_vld     <= keep;
            out_tgt     <= fwd_tgt;
            rd_valid    <= any_trig;
            rd_tid      <= w_tid;
            rd_seq      <= w_seq;
            rd_next_pc  <= w_pc;
            rd_taken    <= w_taken;
            rd_ctrl_bad <= any_trig && (w_cause == CAUSE_NOTCTRL);
            rd_tgt_bad  <= any_trig && (w_cause == CAUSE_TARGET);
        end
    end

    brchk_kill_mask #(.D(D), .TW(TW), .SW(SW)) u_kill (
        .rd_valid(rd_valid),
        .rd_tid  (rd_tid),
        .rd_seq  (rd_seq),
        .sk_vld  (sk_vld),
        .sk_tid  (sk_tid),
        .sk_seq  (sk_seq),
        .kill    (sk_kill)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic squash_t;
        assign squash_t = any_trig && (w_tid == TW'(t));
        brchk_thread_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .blk_req      (blk_req[t]),
            .squash       (squash_t),
            .fetch_block  (fetch_block[t]),
            .fetch_unblock(fetch_unblock[t])
        );
    end

    // R4
    taken_on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_tgt_bad |-> rd_taken);

    // R2
    notctrl_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl_bad |-> rd_valid && !rd_taken);

    // R6
    cause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_ctrl_bad != rd_tgt_bad));

    // R7
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_trig |-> $onehot(win_oh));

    // R10
    kill_needs_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_kill != '0) |-> rd_valid);

endmodule

// File: tb/sim_decode_branch_check.sv
module sim_decode_branch_check;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4, T = 2, SW = 16, AW = 32, D = 8, TW = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0]    in_vld, in_ctrl, in_direct, in_uncond, in_pred_taken;
    logic [W*TW-1:0] in_tid;
    logic [W*SW-1:0] in_seq;
    logic [W*AW-1:0] in_pc, in_pred_tgt, in_calc_tgt;
    logic [W-1:0]    out_vld;
    logic [W*AW-1:0] out_tgt;
    logic            rd_valid, rd_taken, rd_ctrl_bad, rd_tgt_bad;
    logic [TW-1:0]   rd_tid;
    logic [SW-1:0]   rd_seq;
    logic [AW-1:0]   rd_next_pc;
    logic [D-1:0]    sk_vld, sk_kill;
    logic [D*TW-1:0] sk_tid;
    logic [D*SW-1:0] sk_seq;
    logic [T-1:0]    blk_req, fetch_block, fetch_unblock;

    decode_branch_check u0 (.*);

    // stimulus arrays
    logic          s_vld[W], s_ctrl[W], s_dir[W], s_unc[W], s_pt[W];
    logic [TW-1:0] s_tid[W];
    logic [SW-1:0] s_seq[W];
    logic [AW-1:0] s_pc[W], s_ptg[W], s_ctg[W];
    logic          k_vld[D];
    logic [TW-1:0] k_tid[D];
    logic [SW-1:0] k_seq[D];

    typedef struct {
        bit            rv;
        bit [TW-1:0]   rtid;
        bit [SW-1:0]   rseq;
        bit [AW-1:0]   rpc;
        bit            rtk, rcb, rtb;
        bit [W-1:0]    ov;
        bit [W*AW-1:0] ot;
        bit [D-1:0]    kill;
        bit [T-1:0]    blk, unb;
        string         tag;
    } exp_t;

    exp_t q[$];
    bit   mst[T];
    int   checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input string tag,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, expv);
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < W; i++) begin
            s_vld[i] = 0; s_ctrl[i] = 0; s_dir[i] = 0; s_unc[i] = 0; s_pt[i] = 0;
            s_tid[i] = 0; s_seq[i] = 0; s_pc[i] = 0; s_ptg[i] = 0; s_ctg[i] = 0;
        end
    endtask

    task automatic set_slot(input int i, input bit tid, input int seq, input int pc,
                            input bit ctrl, input bit dir, input bit unc, input bit pt,
                            input int ptg, input int ctg);
        s_vld[i] = 1; s_tid[i] = tid; s_seq[i] = SW'(seq); s_pc[i] = AW'(pc);
        s_ctrl[i] = ctrl; s_dir[i] = dir; s_unc[i] = unc; s_pt[i] = pt;
        s_ptg[i] = AW'(ptg); s_ctg[i] = AW'(ctg);
    endtask

    // driver: drive a group, compute expectation from the requirements, push
    task automatic apply(input string tag);
        exp_t e;
        int   cause[W];
        int   win;
        for (int i = 0; i < W; i++) begin
            in_vld[i] = s_vld[i]; in_ctrl[i] = s_ctrl[i]; in_direct[i] = s_dir[i];
            in_uncond[i] = s_unc[i]; in_pred_taken[i] = s_pt[i];
            in_tid[i*TW +: TW] = s_tid[i]; in_seq[i*SW +: SW] = s_seq[i];
            in_pc[i*AW +: AW] = s_pc[i]; in_pred_tgt[i*AW +: AW] = s_ptg[i];
            in_calc_tgt[i*AW +: AW] = s_ctg[i];
        end
        for (int k = 0; k < D; k++) begin
            sk_vld[k] = k_vld[k]; sk_tid[k*TW +: TW] = k_tid[k]; sk_seq[k*SW +: SW] = k_seq[k];
        end
        win = -1;
        for (int i = 0; i < W; i++) begin
            cause[i] = 0;
            if (s_vld[i]) begin
                if (s_pt[i] && !s_ctrl[i]) cause[i] = 1;
                else if (s_ctrl[i] && s_dir[i] && (s_unc[i] || s_pt[i]) && s_ctg[i] != s_ptg[i])
                    cause[i] = 2;
            end
            if (cause[i] != 0 && (win < 0 || s_seq[i] < s_seq[win])) win = i;
        end
        e = '{default: 0};
        e.tag = tag;
        e.rv  = (win >= 0);
        if (e.rv) begin
            e.rtid = s_tid[win];
            e.rseq = s_seq[win];
            e.rpc  = (cause[win] == 1) ? s_pc[win] + 4 : s_ctg[win];
            e.rtk  = (cause[win] == 2);
            e.rcb  = (cause[win] == 1);
            e.rtb  = (cause[win] == 2);
        end
        for (int i = 0; i < W; i++) begin
            e.ov[i] = s_vld[i] && !(e.rv && s_tid[i] == e.rtid && s_seq[i] > e.rseq);
            e.ot[i*AW +: AW] = (i == win && cause[i] == 2) ? s_ctg[i] : s_ptg[i];
        end
        for (int k = 0; k < D; k++)
            e.kill[k] = e.rv && k_vld[k] && k_tid[k] == e.rtid && k_seq[k] > e.rseq;
        for (int t = 0; t < T; t++) begin
            bit sq;
            sq = e.rv && (e.rtid == TW'(t));
            e.unb[t] = sq || (mst[t] && !blk_req[t]);
            mst[t]   = !sq && blk_req[t];
            e.blk[t] = mst[t];
        end
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare each result one cycle after its group
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(rd_valid == e.rv, "R6", e.tag, rd_valid, e.rv);
                if (e.rv && rd_valid) begin
                    chk(rd_seq == e.rseq && rd_tid == e.rtid, "R7", e.tag,
                        {rd_tid, rd_seq}, {e.rtid, e.rseq});
                    chk(rd_next_pc == e.rpc, e.rcb ? "R2" : "R3", e.tag, rd_next_pc, e.rpc);
                    chk(rd_taken == e.rtk, "R4", e.tag, rd_taken, e.rtk);
                    chk(rd_ctrl_bad == e.rcb && rd_tgt_bad == e.rtb, "R3", e.tag,
                        {rd_ctrl_bad, rd_tgt_bad}, {e.rcb, e.rtb});
                end
                chk(out_vld == e.ov, "R8", e.tag, out_vld, e.ov);
                for (int i = 0; i < W; i++)
                    if (e.ov[i])
                        chk(out_tgt[i*AW +: AW] == e.ot[i*AW +: AW], "R9", e.tag,
                            out_tgt[i*AW +: AW], e.ot[i*AW +: AW]);
                chk(sk_kill == e.kill, "R10", e.tag, sk_kill, e.kill);
                chk(fetch_block == e.blk, "R11", e.tag, fetch_block, e.blk);
                chk(fetch_unblock == e.unb, "R12", e.tag, fetch_unblock, e.unb);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_slots();
        for (int k = 0; k < D; k++) begin
            k_vld[k] = 1; k_tid[k] = TW'(k % 2); k_seq[k] = SW'(100 + 10 * k);
        end
        k_vld[7] = 0;
        for (int t = 0; t < T; t++) mst[t] = 0;
        in_vld = '0; in_ctrl = '0; in_direct = '0; in_uncond = '0; in_pred_taken = '0;
        in_tid = '0; in_seq = '0; in_pc = '0; in_pred_tgt = '0; in_calc_tgt = '0;
        sk_vld = '1; sk_tid = '0; sk_seq = '1; blk_req = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(rd_valid == 0 && out_vld == 0 && sk_kill == 0, "R1", "reset",
            {rd_valid, out_vld, sk_kill}, 0);
        chk(fetch_block == 0 && fetch_unblock == 0, "R1", "reset",
            {fetch_block, fetch_unblock}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 plain group, nothing mispredicted
        clear_slots();
        set_slot(0, 0, 10, 'h1000, 0, 0, 0, 0, 0, 0);
        set_slot(1, 1, 11, 'h2000, 1, 1, 0, 0, 'h3000, 'h3400);
        set_slot(2, 0, 12, 'h1004, 1, 1, 1, 1, 'h5000, 'h5000);
        set_slot(3, 1, 13, 'h2004, 1, 0, 0, 1, 'h6000, 'h6100);
        apply("R5_clean");

        // R5 invalid slot carrying a bad pattern
        clear_slots();
        set_slot(1, 0, 20, 'h1100, 0, 0, 0, 1, 0, 0);
        s_vld[1] = 0;
        apply("R5_invalid");

        // R2 non-control predicted taken; R8 younger same thread dropped
        clear_slots();
        set_slot(0, 0, 104, 'h1200, 0, 0, 0, 0, 0, 0);
        set_slot(1, 0, 105, 'h1204, 0, 0, 0, 1, 'h9000, 0);
        set_slot(2, 0, 106, 'h1208, 0, 0, 0, 0, 0, 0);
        set_slot(3, 1, 107, 'h2208, 0, 0, 0, 0, 0, 0);
        apply("R2_notctrl");

        // R4 unconditional predicted not taken with wrong target; R9
        clear_slots();
        set_slot(0, 1, 115, 'h2300, 1, 1, 1, 0, 'h0, 'h4400);
        set_slot(1, 1, 116, 'h2304, 0, 0, 0, 0, 'h77, 0);
        set_slot(2, 0, 117, 'h1300, 0, 0, 0, 0, 'h88, 0);
        apply("R4_uncond");

        // R3 conditional predicted taken, target mismatch; R10 kill
        clear_slots();
        set_slot(0, 0, 95, 'h1400, 0, 0, 0, 0, 'h11, 0);
        set_slot(1, 0, 125, 'h1404, 1, 1, 0, 1, 'h5000, 'h5080);
        set_slot(2, 1, 126, 'h2404, 1, 1, 0, 1, 'h6000, 'h6080);
        set_slot(3, 0, 127, 'h1408, 0, 0, 0, 0, 'h22, 0);
        apply("R3_cond");

        // R5 cond not taken mismatch, indirect mismatch, matching target
        clear_slots();
        set_slot(0, 0, 140, 'h1500, 1, 1, 0, 0, 'h100, 'h200);
        set_slot(1, 0, 141, 'h1504, 1, 0, 1, 1, 'h300, 'h400);
        set_slot(2, 1, 142, 'h2504, 1, 1, 1, 1, 'h500, 'h500);
        apply("R5_nojudge");

        // R7 oldest wins regardless of slot index and thread
        clear_slots();
        set_slot(0, 1, 150, 'h2600, 1, 1, 1, 1, 'h10, 'h20);
        set_slot(1, 0, 152, 'h1604, 0, 0, 0, 0, 'h30, 0);
        set_slot(2, 0, 140, 'h1600, 0, 0, 0, 1, 'h40, 0);
        set_slot(3, 1, 155, 'h2604, 0, 0, 0, 0, 'h50, 0);
        apply("R7_oldest");

        // back-to-back redirects on alternating threads
        clear_slots();
        set_slot(3, 1, 102, 'h2700, 1, 1, 0, 1, 'h10, 'h18);
        apply("R6_b2b_a");
        clear_slots();
        set_slot(0, 0, 110, 'h1700, 1, 1, 1, 1, 'h20, 'h28);
        set_slot(1, 0, 111, 'h1704, 1, 1, 1, 1, 'h30, 'h38);
        apply("R6_b2b_b");

        // R11 block and release on thread 1
        clear_slots();
        blk_req = 2'b10;
        apply("R11_stall");
        apply("R11_held");
        blk_req = 2'b00;
        apply("R11_resume");
        apply("R11_idle");

        // R12 squash on a blocked thread with request still high
        blk_req = 2'b01;
        apply("R12_stall");
        set_slot(0, 0, 130, 'h1800, 0, 0, 0, 1, 0, 0);
        apply("R12_flush");
        clear_slots();
        apply("R12_restall");
        blk_req = 2'b00;
        apply("R12_release");
        apply("tail");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule